// File: doc/BRIEF.md
# Oscillator Failure Guard with Backup Clock Handover

This block watches a main oscillator against a reference RC oscillator that is always running. It decides whether the main clock is healthy by counting transitions of a prescaled copy of the main clock inside a fixed window of RC cycles. When too few transitions arrive, the main clock is treated as stopped or too slow. The system clock is then taken from the RC source and a watchdog reset request is raised.

When the main clock recovers, the block keeps the RC clock and the reset for a timed stabilization interval. It then hands the system clock back to the main oscillator through a glitch-free two-flop handshake and drops its request. A new failure during the stabilization interval aborts it.

The chip reset is the OR of the watchdog request and a synchronized external reset. A sticky cause flag records that the watchdog was active, and a second flag serves the watchdog timer. Software can write both flags, and the external reset clears both. After power-on reset the block starts in the failed state, so the device is held in reset on the RC clock from the first instant.

Top module: `clkfail_guard`

## Requirements
- R1: When fewer than THRESH transitions of the prescaled main clock (most significant bit of a PRE_W-bit counter on main_clk) are seen in a window of WIN_CYC rc_clk cycles, wd_req is asserted at the end of that window. A stopped or slow main clock therefore raises wd_req within two windows.
- R2: While the failure holds, wd_req stays 1, clk_on_rc is 1 and clk_on_main is 0, so sys_clk is driven by rc_clk.
- R3: After a window with at least THRESH transitions, a final reset interval of exactly FINAL_CYC rc_clk cycles runs before wd_req falls. Throughout the interval clk_on_rc stays 1.
- R4: When wd_req falls, the RC branch is disabled on an rc_clk falling edge before the main branch is enabled on a main_clk falling edge. clk_on_rc and clk_on_main are never 1 together, and sys_clk shows no pulse shorter than the shorter half-period of the two sources.
- R5: chip_rst equals wd_req OR ext_rst after ext_rst passes through SYNC_STAGES rc_clk flops. With the default of 2 stages, chip_rst follows ext_rst on the second rc_clk rising edge.
- R6: In every cycle where wd_req is 1 and the synchronized external reset is 0, osc_flag is 1 after the next rc_clk edge.
- R7: A synchronized external reset clears osc_flag and tmr_flag on the next rc_clk edge.
- R8: While rc_rst_n is low, wd_req=1, chip_rst=1, clk_on_rc=1 and clk_on_main=0.
- R9: A write with sw_we=1 loads sw_wdata bit 0 into osc_flag and bit 1 into tmr_flag. A tmr_evt pulse sets tmr_flag. Priority is external reset clear first, then hardware set (wd_req or tmr_evt), then the software write.
- R10: A window with fewer than THRESH transitions during the final reset interval aborts it and returns the block to the failed state. wd_req does not fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Always-running reference RC clock |
| rc_rst_n | input | 1 | Asynchronous active-low power-on reset |
| main_clk | input | 1 | Main oscillator clock under observation |
| ext_rst | input | 1 | External reset request, active high, asynchronous |
| sw_we | input | 1 | Software write strobe for the flag register |
| sw_wdata | input | 2 | Write data: bit 0 osc_flag, bit 1 tmr_flag |
| tmr_evt | input | 1 | Set pulse for the watchdog-timer flag |
| sys_clk | output | 1 | Glitch-free selected system clock |
| clk_on_rc | output | 1 | RC branch of the clock switch enabled |
| clk_on_main | output | 1 | Main branch of the clock switch enabled |
| wd_req | output | 1 | Watchdog reset request |
| chip_rst | output | 1 | Combined chip reset request |
| osc_flag | output | 1 | Sticky oscillator-watchdog cause flag |
| tmr_flag | output | 1 | Watchdog-timer status flag |

## Verification
Results fall into two groups. Flag writes land one rc_clk edge after the strobe, and chip_rst follows ext_rst on the second edge. The bench samples these on the falling edge of rc_clk at exactly those counts. The failure and recovery decisions depend on where a window boundary falls, so the bench waits for them with bounds derived from WIN_CYC, FINAL_CYC and the synchronizer depth: the final reset must last at least FINAL_CYC and at most FINAL_CYC plus three windows. Clock handover is checked within a few cycles of wd_req falling, and a pulse-width monitor on sys_clk covers the whole run.

// File: rtl/clkfail_pkg.sv
package clkfail_pkg;
   typedef enum logic [1:0] {
      WD_FAIL  = 2'd0,
      WD_FINAL = 2'd1,
      WD_RUN   = 2'd2
   } wd_state_e;
endpackage

// File: rtl/clkfail_sync.sv
module clkfail_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("clkfail_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkfail_freqmon.sv
module clkfail_freqmon #(
   parameter int PRE_W       = 4,
   parameter int WIN_CYC     = 64,
   parameter int THRESH      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic rc_clk,
   input  logic rc_rst_n,
   input  logic main_clk,
   output logic win_done,
   output logic win_ok
);
   localparam int WW = $clog2(WIN_CYC);
   localparam int CW = $clog2(THRESH + 1);

   logic [PRE_W-1:0] pre_q;
   logic             tog_s, tog_d, edge_seen, last_cyc;
   logic [WW-1:0]    win_q;
   logic [CW-1:0]    cnt_q, cnt_nx;

   // prescaler in the main clock domain
   always_ff @(posedge main_clk or negedge rc_rst_n) begin
      if (!rc_rst_n) pre_q <= '0;
      else           pre_q <= pre_q + 1'b1;
   end

   clkfail_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tog_sync (
      .clk   (rc_clk),
      .rst_n (rc_rst_n),
      .d     (pre_q[PRE_W-1]),
      .q     (tog_s)
   );

   always_ff @(posedge rc_clk or negedge rc_rst_n) begin
      if (!rc_rst_n) tog_d <= 1'b0;
      else           tog_d <= tog_s;
   end

   assign edge_seen = tog_s ^ tog_d;
   assign last_cyc  = (win_q == WW'(WIN_CYC - 1));
   assign cnt_nx    = (edge_seen && (cnt_q < CW'(THRESH))) ? cnt_q + 1'b1 : cnt_q;

   always_ff @(posedge rc_clk or negedge rc_rst_n) begin
      if (!rc_rst_n) begin
         win_q    <= '0;
         cnt_q    <= '0;
         win_done <= 1'b0;
         win_ok   <= 1'b0;
      end else if (last_cyc) begin
         win_q    <= '0;
         cnt_q    <= '0;
         win_done <= 1'b1;
         win_ok   <= (cnt_nx >= CW'(THRESH));
      end else begin
         win_q    <= win_q + 1'b1;
         cnt_q    <= cnt_nx;
         win_done <= 1'b0;
      end
   end
endmodule

// File: rtl/clkfail_seq.sv
module clkfail_seq
   import clkfail_pkg::*;
#(
   parameter int FINAL_CYC = 1000
) (
   input  logic rc_clk,
   input  logic rc_rst_n,
   input  logic win_done,
   input  logic win_ok,
   output logic req_q,
   output logic kill_q
);
   localparam int TW = $clog2(FINAL_CYC + 1);

   wd_state_e     st_q, st_nx;
   logic [TW-1:0] tmr_q;

   always_comb begin
      st_nx = st_q;
      unique case (st_q)
         WD_FAIL:  if (win_done && win_ok) st_nx = WD_FINAL;
         WD_FINAL: if (win_done && !win_ok) st_nx = WD_FAIL;
                   else if (tmr_q == '0)    st_nx = WD_RUN;
         WD_RUN:   if (win_done && !win_ok) st_nx = WD_FAIL;
         default:  st_nx = WD_FAIL;
      endcase
   end

   always_ff @(posedge rc_clk or negedge rc_rst_n) begin
      if (!rc_rst_n) begin
         st_q   <= WD_FAIL;
         tmr_q  <= '0;
         req_q  <= 1'b1;
         kill_q <= 1'b1;
      end else begin
         st_q   <= st_nx;
         req_q  <= (st_nx != WD_RUN);
         kill_q <= (st_nx == WD_FAIL);
         if (st_q != WD_FINAL && st_nx == WD_FINAL) tmr_q <= TW'(FINAL_CYC - 1);
         else if (st_q == WD_FINAL && tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
      end
   end
endmodule

// File: rtl/clkfail_clkmux.sv
module clkfail_clkmux #(
   parameter int SYNC_STAGES = 2
) (
   input  logic rc_clk,
   input  logic rc_rst_n,
   input  logic main_clk,
   input  logic sel_rc,
   input  logic kill_main,
   output logic sys_clk,
   output logic on_rc,
   output logic on_main
);
   logic main_rst_n, want_m, want_r, want_m_s, want_r_s;

   // a dead main clock cannot retire its own enable: clear it directly
   assign main_rst_n = ~kill_main;
   assign want_m     = ~sel_rc & ~on_rc;
   assign want_r     = sel_rc & ~on_main;

   clkfail_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_msync (
      .clk   (main_clk),
      .rst_n (main_rst_n),
      .d     (want_m),
      .q     (want_m_s)
   );

   clkfail_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rsync (
      .clk   (rc_clk),
      .rst_n (rc_rst_n),
      .d     (want_r),
      .q     (want_r_s)
   );

   always_ff @(negedge main_clk or negedge main_rst_n) begin
      if (!main_rst_n) on_main <= 1'b0;
      else             on_main <= want_m_s;
   end

   always_ff @(negedge rc_clk or negedge rc_rst_n) begin
      if (!rc_rst_n) on_rc <= 1'b1;
      else           on_rc <= want_r_s;
   end

   assign sys_clk = (main_clk & on_main) | (rc_clk & on_rc);
endmodule

// File: rtl/clkfail_flags.sv
module clkfail_flags (
   input  logic       rc_clk,
   input  logic       rc_rst_n,
   input  logic       clr,
   input  logic       osc_set,
   input  logic       tmr_set,
   input  logic       sw_we,
   input  logic [1:0] sw_wdata,
   output logic       osc_q,
   output logic       tmr_q
);
   always_ff @(posedge rc_clk or negedge rc_rst_n) begin
      if (!rc_rst_n) begin
         osc_q <= 1'b0;
         tmr_q <= 1'b0;
      end else begin
         if (clr)          osc_q <= 1'b0;
         else if (osc_set) osc_q <= 1'b1;
         else if (sw_we)   osc_q <= sw_wdata[0];

         if (clr)          tmr_q <= 1'b0;
         else if (tmr_set) tmr_q <= 1'b1;
         else if (sw_we)   tmr_q <= sw_wdata[1];
      end
   end
endmodule

// File: rtl/clkfail_guard.sv
module clkfail_guard #(
   parameter int PRE_W       = 4,
   parameter int WIN_CYC     = 64,
   parameter int THRESH      = WIN_CYC >> (PRE_W - 1),
   parameter int FINAL_CYC   = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       rc_clk,
   input  logic       rc_rst_n,
   input  logic       main_clk,
   input  logic       ext_rst,
   input  logic       sw_we,
   input  logic [1:0] sw_wdata,
   input  logic       tmr_evt,
   output logic       sys_clk,
   output logic       clk_on_rc,
   output logic       clk_on_main,
   output logic       wd_req,
   output logic       chip_rst,
   output logic       osc_flag,
   output logic       tmr_flag
);
   generate
      if (PRE_W < 1)                   begin : g_bad_pre   $error("PRE_W must be at least 1"); end
      if (WIN_CYC < 2)                 begin : g_bad_win   $error("WIN_CYC must be at least 2"); end
      if (THRESH < 1 || THRESH > WIN_CYC) begin : g_bad_thr $error("THRESH out of range"); end
      if (FINAL_CYC < 1)               begin : g_bad_final $error("FINAL_CYC must be at least 1"); end
   endgenerate

   logic win_done, win_ok, kill_main, ext_s;

   clkfail_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
      .clk   (rc_clk),
      .rst_n (rc_rst_n),
      .d     (ext_rst),
      .q     (ext_s)
   );

   clkfail_freqmon #(
      .PRE_W(PRE_W), .WIN_CYC(WIN_CYC), .THRESH(THRESH), .SYNC_STAGES(SYNC_STAGES)
   ) u_mon (
      .rc_clk   (rc_clk),
      .rc_rst_n (rc_rst_n),
      .main_clk (main_clk),
      .win_done (win_done),
      .win_ok   (win_ok)
   );

   clkfail_seq #(.FINAL_CYC(FINAL_CYC)) u_seq (
      .rc_clk   (rc_clk),
      .rc_rst_n (rc_rst_n),
      .win_done (win_done),
      .win_ok   (win_ok),
      .req_q    (wd_req),
      .kill_q   (kill_main)
   );

   clkfail_clkmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
      .rc_clk    (rc_clk),
      .rc_rst_n  (rc_rst_n),
      .main_clk  (main_clk),
      .sel_rc    (wd_req),
      .kill_main (kill_main),
      .sys_clk   (sys_clk),
      .on_rc     (clk_on_rc),
      .on_main   (clk_on_main)
   );

   clkfail_flags u_flags (
      .rc_clk   (rc_clk),
      .rc_rst_n (rc_rst_n),
      .clr      (ext_s),
      .osc_set  (wd_req),
      .tmr_set  (tmr_evt),
      .sw_we    (sw_we),
      .sw_wdata (sw_wdata),
      .osc_q    (osc_flag),
      .tmr_q    (tmr_flag)
   );

   assign chip_rst = wd_req | ext_s;
endmodule

// File: rtl/clkfail_guard_chk.sv
module clkfail_guard_chk (
   input logic rc_clk,
   input logic rc_rst_n,
   input logic wd_req,
   input logic chip_rst,
   input logic ext_s,
   input logic clk_on_rc,
   input logic clk_on_main,
   input logic osc_flag,
   input logic tmr_flag
);
   p_req_in_chip_r5: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      wd_req |-> chip_rst);

   p_ext_in_chip_r5: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      ext_s |-> chip_rst);

   p_no_dual_r4: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      !(clk_on_rc && clk_on_main));

   p_main_off_r2: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      wd_req |-> !clk_on_main);

   p_rc_at_release_r3: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      $fell(wd_req) |-> clk_on_rc);

   p_flag_set_r6: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      (wd_req && !ext_s) |=> osc_flag);

   p_ext_clear_r7: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      ext_s |=> (!osc_flag && !tmr_flag));
endmodule

bind clkfail_guard clkfail_guard_chk u_chk (
   .rc_clk      (rc_clk),
   .rc_rst_n    (rc_rst_n),
   .wd_req      (wd_req),
   .chip_rst    (chip_rst),
   .ext_s       (ext_s),
   .clk_on_rc   (clk_on_rc),
   .clk_on_main (clk_on_main),
   .osc_flag    (osc_flag),
   .tmr_flag    (tmr_flag)
);

// File: tb/sim_clkfail_guard.sv
`timescale 1ns/1ps
module sim_clkfail_guard;
   localparam int RC_PERIOD = 10;
   localparam int PRE_W     = 2;
   localparam int WIN       = 32;
   localparam int THR       = 8;
   localparam int FIN       = 200;
   localparam int WD_LIMIT  = 20000;

   logic rc_clk = 1'b0, main_clk = 1'b0, rc_rst_n = 1'b1;
   logic ext_rst = 1'b0, sw_we = 1'b0, tmr_evt = 1'b0;
   logic [1:0] sw_wdata = 2'b00;
   logic sys_clk, clk_on_rc, clk_on_main, wd_req, chip_rst, osc_flag, tmr_flag;

   int  errors = 0, checks = 0;
   bit  done = 0;
   bit  main_run = 0;
   int  main_half = 3;
   bit  mon_en = 0;
   int  short_pulses = 0;
   int  sys_edges = 0;
   realtime last_t = 0.0;

   clkfail_guard #(
      .PRE_W(PRE_W), .WIN_CYC(WIN), .THRESH(THR), .FINAL_CYC(FIN), .SYNC_STAGES(2)
   ) u0 (
      .rc_clk(rc_clk), .rc_rst_n(rc_rst_n), .main_clk(main_clk), .ext_rst(ext_rst),
      .sw_we(sw_we), .sw_wdata(sw_wdata), .tmr_evt(tmr_evt), .sys_clk(sys_clk),
      .clk_on_rc(clk_on_rc), .clk_on_main(clk_on_main), .wd_req(wd_req),
      .chip_rst(chip_rst), .osc_flag(osc_flag), .tmr_flag(tmr_flag)
   );

   initial forever #(RC_PERIOD / 2) rc_clk = ~rc_clk;

   initial forever begin
      if (main_run) begin
         #(main_half) main_clk = 1'b1;
         #(main_half) main_clk = 1'b0;
      end else #1;
   end

   always @(sys_clk) begin
      sys_edges++;
      if (mon_en && last_t > 0.0 && ($realtime - last_t) < 2.9) short_pulses++;
      last_t = $realtime;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge rc_clk);
   endtask

   task automatic sw_write(input logic [1:0] v, input bit evt);
      sw_wdata = v; sw_we = 1'b1; tmr_evt = evt;
      cyc(1);
      sw_we = 1'b0; tmr_evt = 1'b0;
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge rc_clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n, bad;
      #1 rc_rst_n = 1'b0;
      #1;
      // R8: reset state
      chk(wd_req && chip_rst && clk_on_rc && !clk_on_main, "R8 reset state",
          {wd_req, chip_rst, clk_on_rc, clk_on_main}, 4'b1110);
      cyc(3);
      rc_rst_n = 1'b1;
      mon_en = 1'b1;
      cyc(2);
      chk(osc_flag == 1'b1, "R6 flag set while failed", osc_flag, 1);

      // R1/R2: stopped main clock keeps failure
      bad = 0;
      for (int i = 0; i < 200; i++) begin
         cyc(1);
         if (!(wd_req && clk_on_rc && !clk_on_main)) bad++;
      end
      chk(bad == 0, "R1 R2 stopped main held in failure", bad, 0);

      // R1: slow main (4 transitions per window) is a failure
      main_half = 20; main_run = 1;
      bad = 0;
      for (int i = 0; i < 200; i++) begin
         cyc(1);
         if (!(wd_req && clk_on_rc && !clk_on_main)) bad++;
      end
      chk(bad == 0, "R1 slow main held in failure", bad, 0);
      main_run = 0;
      cyc(10);

      // R3: recovery with a final reset of FIN cycles on the RC clock
      main_half = 3; main_run = 1;
      n = 0; bad = 0;
      while (wd_req && n < 600) begin
         cyc(1); n++;
         if (!clk_on_rc) bad++;
      end
      chk(n >= FIN && n <= FIN + 3 * WIN + 10, "R3 final reset length", n, FIN);
      chk(bad == 0, "R3 clock stays on RC during final reset", bad, 0);

      // R4: handover to main
      n = 0;
      while (clk_on_rc && n < 8) begin cyc(1); n++; end
      chk(!clk_on_rc, "R4 RC branch released", clk_on_rc, 0);
      n = 0;
      while (!clk_on_main && n < 8) begin cyc(1); n++; end
      chk(clk_on_main, "R4 main branch enabled", clk_on_main, 1);
      chk(!chip_rst, "R5 chip reset released", chip_rst, 0);
      sys_edges = 0;
      cyc(30);
      chk(sys_edges >= 90, "R4 sys_clk follows main", sys_edges, 100);

      // R9: software access and timer flag
      sw_write(2'b00, 1'b0); cyc(1);
      chk({tmr_flag, osc_flag} == 2'b00, "R9 write 00", {tmr_flag, osc_flag}, 0);
      sw_write(2'b11, 1'b0); cyc(1);
      chk({tmr_flag, osc_flag} == 2'b11, "R9 write 11", {tmr_flag, osc_flag}, 3);
      sw_write(2'b01, 1'b0); cyc(1);
      chk({tmr_flag, osc_flag} == 2'b01, "R9 write 01", {tmr_flag, osc_flag}, 1);
      sw_write(2'b00, 1'b1); cyc(1);
      chk({tmr_flag, osc_flag} == 2'b10, "R9 timer set beats write", {tmr_flag, osc_flag}, 2);
      sw_write(2'b11, 1'b0);

      // R5/R7: external reset
      ext_rst = 1'b1;
      cyc(1);
      chk(!chip_rst, "R5 ext after one edge", chip_rst, 0);
      cyc(1);
      chk(chip_rst && !wd_req, "R5 ext after two edges", chip_rst, 1);
      cyc(1);
      chk({tmr_flag, osc_flag} == 2'b00, "R7 ext clears flags", {tmr_flag, osc_flag}, 0);
      sw_write(2'b11, 1'b0); cyc(1);
      chk({tmr_flag, osc_flag} == 2'b00, "R9 R7 write ignored under ext", {tmr_flag, osc_flag}, 0);
      ext_rst = 1'b0;
      cyc(2);
      chk(!chip_rst, "R5 ext release", chip_rst, 0);

      // R1/R2: failover from a running main clock
      main_run = 0;
      n = 0;
      while (!wd_req && n < 2 * WIN + 10) begin cyc(1); n++; end
      chk(wd_req, "R1 failure detected", wd_req, 1);
      chk(!clk_on_main, "R2 main branch cut", clk_on_main, 0);
      n = 0;
      while (!clk_on_rc && n < 6) begin cyc(1); n++; end
      chk(clk_on_rc && chip_rst, "R2 RC branch and reset", {clk_on_rc, chip_rst}, 3);
      cyc(1);
      chk(osc_flag, "R6 flag after failover", osc_flag, 1);
      sw_write(2'b00, 1'b0); cyc(1);
      chk(osc_flag, "R9 hardware set beats write", osc_flag, 1);

      // R10: abort of the final reset
      main_half = 6; main_run = 1;
      cyc(3 * WIN);
      main_run = 0;
      bad = 0;
      for (int i = 0; i < FIN + 200; i++) begin
         cyc(1);
         if (!wd_req) bad++;
      end
      chk(bad == 0, "R10 final reset aborted", bad, 0);

      // R5: external reset held across watchdog release
      ext_rst = 1'b1;
      main_half = 3; main_run = 1;
      n = 0;
      while (wd_req && n < 600) begin cyc(1); n++; end
      chk(!wd_req && chip_rst, "R5 ext keeps chip reset", {wd_req, chip_rst}, 1);
      cyc(20);
      chk(chip_rst, "R5 chip reset held", chip_rst, 1);
      ext_rst = 1'b0;
      cyc(3);
      chk(!chip_rst, "R5 chip reset released after ext", chip_rst, 0);
      chk(short_pulses == 0, "R4 no short sys_clk pulse", short_pulses, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule